// File: doc/BRIEF.md
# Operand-Snooping Reservation Pool

This block is a small pool of waiting slots placed in front of one class of functional unit. An upstream issue stage hands it an operation together with two source operands. Each operand comes either as a finished value or as the tag of the slot that will later produce it. The pool stores the operation in the lowest free slot and tells the issue stage which tag that slot owns. When every slot is occupied, the pool raises a full flag and the issue stage must hold back.

Every cycle, occupied slots watch a shared result bus. A slot whose pending tag matches the tag on the bus takes the value from the bus and stops waiting on that operand. A slot with both operands resolved is offered to the functional unit on a dispatch port. The lowest such slot is offered first. Once the unit accepts the offer, the slot is marked as in flight, and it stays occupied until its own result appears on the bus. The slot is released on the clock edge that follows that broadcast.

Top module: `rsv_pool`

## Requirements
- R1: After a synchronous active-low reset, every slot is free: `iss_full` is 0, `disp_valid` is 0 and `iss_tag` is 1.
- R2: Slot i (counting from 0) owns result tag i+1. `iss_tag` always shows the tag of the lowest-numbered free slot, and an accepted issue (`iss_valid` high while `iss_full` is low) fills that slot.
- R3: `iss_full` is 1 exactly when all slots are occupied. An issue request made while `iss_full` is 1 changes no slot.
- R4: An operand tag of 0 means the accompanying value is valid. A nonzero tag means the operand is still pending. A slot is offered for dispatch only when both of its operand tags are 0.
- R5: When `bus_valid` is 1 with a nonzero `bus_tag`, every occupied slot with a pending operand tag equal to `bus_tag` stores `bus_value` in that operand and clears the tag. The slot can be offered on the following cycle.
- R6: If an issued operand tag equals a nonzero `bus_tag` broadcast in the same cycle, the operand is stored as already resolved with `bus_value`.
- R7: `disp_valid` offers the lowest-numbered slot that is ready and not yet in flight, with its tag, opcode and both operand values. The offered slot is launched only in a cycle where `disp_ready` is 1, and at most one slot is launched per cycle.
- R8: A launched slot stays occupied but is never offered again.
- R9: A broadcast of a slot's own tag frees that slot on the next clock edge. This takes precedence over a launch or a snoop in the same cycle, and the freed slot becomes available to issue.
- R10: The 2-bit opcode (0 add, 1 subtract, 2 multiply, 3 divide) is delivered unchanged on `disp_op`.
- R11: A broadcast with `bus_valid` at 0, or with `bus_tag` equal to 0, changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode of the issued operation |
| iss_vj | input | 32 | First operand value |
| iss_qj | input | 4 | First operand producer tag (0 = value valid) |
| iss_vk | input | 32 | Second operand value |
| iss_qk | input | 4 | Second operand producer tag (0 = value valid) |
| iss_full | output | 1 | All slots occupied |
| iss_tag | output | 4 | Tag of the slot the next issue will take |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | 4 | Tag of the broadcast result |
| bus_value | input | 32 | Broadcast result value |
| disp_ready | input | 1 | Functional unit accepts an operation |
| disp_valid | output | 1 | A ready slot is offered |
| disp_tag | output | 4 | Tag of the offered slot |
| disp_op | output | 2 | Opcode of the offered slot |
| disp_a | output | 32 | First operand of the offered slot |
| disp_b | output | 32 | Second operand of the offered slot |

## Verification
The embedded properties watch five things on every cycle: issue never lands on an occupied slot, at most one slot is launched, an in-flight slot is never relaunched, a matching broadcast is captured on the next edge, and a slot's own broadcast frees it. Other behaviours only show up over a sequence of cycles, so they come from bench scenarios compared against a slot-level model. These are lowest-index choice under contention, same-cycle capture at issue, rejected issues while the pool is full, inert broadcasts, and slot reuse after release.

// File: rtl/rsv_pkg.sv
// Shared definitions for the reservation pool: opcode encoding.
package rsv_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rsv_op_e;

endpackage

// File: rtl/rsv_lowest.sv
// Lowest-index picker: given a request vector, returns a one-hot grant for
// the lowest set bit, its index, and whether any bit was set.
// Assumes N >= 1; purely combinational.
module rsv_lowest #(
    parameter int N  = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan upward and stop at the first requester.
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsv_entry.sv
// One reservation slot: holds an opcode and two operands, each either a
// value or a pending producer tag. It snoops the result bus, reports
// readiness, and frees itself when its own tag is broadcast.
// Assumes the caller only loads it while it is free and only launches it
// while it reports ready.
module rsv_entry #(
    parameter int              DATA_W  = 32,
    parameter int              TAG_W   = 4,
    parameter logic [TAG_W-1:0] ENT_TAG = 4'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  rsv_pkg::rsv_op_e     ld_op,
    input  logic [DATA_W-1:0]    ld_vj,
    input  logic [TAG_W-1:0]     ld_qj,
    input  logic [DATA_W-1:0]    ld_vk,
    input  logic [TAG_W-1:0]     ld_qk,
    input  logic                 bus_valid,
    input  logic [TAG_W-1:0]     bus_tag,
    input  logic [DATA_W-1:0]    bus_value,
    input  logic                 launch,
    output logic                 busy,
    output logic                 ready,
    output rsv_pkg::rsv_op_e     op,
    output logic [DATA_W-1:0]    vj,
    output logic [DATA_W-1:0]    vk
);

    logic             in_flight;
    logic [TAG_W-1:0] qj;
    logic [TAG_W-1:0] qk;
    logic             bus_live;
    logic             own_hit;
    logic             ld_hit_j;
    logic             ld_hit_k;
    logic             snoop_j;
    logic             snoop_k;

    // Decode bus matches for loading, snooping and self-release.
    always_comb begin
        bus_live = bus_valid && (bus_tag != '0);
        own_hit  = bus_live && (bus_tag == ENT_TAG);
        ld_hit_j = bus_live && (ld_qj == bus_tag);
        ld_hit_k = bus_live && (ld_qk == bus_tag);
        snoop_j  = bus_live && (qj != '0) && (qj == bus_tag);
        snoop_k  = bus_live && (qk != '0) && (qk == bus_tag);
    end

    // Slot state: load, release, launch and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            in_flight <= 1'b0;
            op        <= rsv_pkg::OP_ADD;
            vj        <= '0;
            vk        <= '0;
            qj        <= '0;
            qk        <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            in_flight <= 1'b0;
            op        <= ld_op;
            vj        <= ld_hit_j ? bus_value : ld_vj;
            qj        <= ld_hit_j ? '0 : ld_qj;
            vk        <= ld_hit_k ? bus_value : ld_vk;
            qk        <= ld_hit_k ? '0 : ld_qk;
        end else if (busy) begin
            if (own_hit) begin
                busy      <= 1'b0;
                in_flight <= 1'b0;
            end else begin
                if (launch) begin
                    in_flight <= 1'b1;
                end
                if (snoop_j) begin
                    vj <= bus_value;
                    qj <= '0;
                end
                if (snoop_k) begin
                    vk <= bus_value;
                    qk <= '0;
                end
            end
        end
    end

    // Offer the slot when both operands are present and it is not in flight.
    always_comb begin
        ready = busy && !in_flight && (qj == '0) && (qk == '0);
    end

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_flight) |-> !launch);  // R8

    AST_SNOOP_TAKES_J: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !own_hit && snoop_j) |=> (qj == '0) && (vj == $past(bus_value)));  // R5

    AST_SNOOP_TAKES_K: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !own_hit && snoop_k) |=> (qk == '0) && (vk == $past(bus_value)));  // R5

    AST_OWN_TAG_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && own_hit) |=> !busy);  // R9

endmodule

// File: rtl/rsv_pool.sv
// Reservation pool for one functional unit class. Allocates the lowest free
// slot on issue, reports full, lets slots snoop the result bus, and offers
// the lowest ready slot for dispatch. Slot i owns tag i+1; tag 0 means
// "value valid". Assumes NUM_ENT < 2**TAG_W and that bus tags name producers.
module rsv_pool #(
    parameter int NUM_ENT = 3,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    localparam int OP_W   = rsv_pkg::OP_W,
    localparam int IW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_full,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              disp_ready,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);

    logic [NUM_ENT-1:0] busy_vec;
    logic [NUM_ENT-1:0] ready_vec;
    logic [NUM_ENT-1:0] free_vec;
    logic [NUM_ENT-1:0] alloc_grant;
    logic [NUM_ENT-1:0] pick_grant;
    logic [NUM_ENT-1:0] load_vec;
    logic [NUM_ENT-1:0] launch_vec;
    logic [IW-1:0]      alloc_idx;
    logic [IW-1:0]      pick_idx;
    logic               free_any;
    logic               pick_any;
    logic               accept;

    rsv_pkg::rsv_op_e   op_arr [NUM_ENT];
    logic [DATA_W-1:0]  vj_arr [NUM_ENT];
    logic [DATA_W-1:0]  vk_arr [NUM_ENT];

    // Free slots are those not occupied.
    always_comb begin
        free_vec = ~busy_vec;
    end

    rsv_lowest #(.N(NUM_ENT)) u_alloc (
        .req   (free_vec),
        .grant (alloc_grant),
        .idx   (alloc_idx),
        .any   (free_any)
    );

    rsv_lowest #(.N(NUM_ENT)) u_pick (
        .req   (ready_vec),
        .grant (pick_grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    // Issue side: full flag, next tag and the load strobe per slot.
    always_comb begin
        iss_full = !free_any;
        iss_tag  = free_any ? (TAG_W'(alloc_idx) + TAG_W'(1)) : '0;
        accept   = iss_valid && free_any;
        load_vec = accept ? alloc_grant : '0;
    end

    // Dispatch side: launch strobe for the offered slot.
    always_comb begin
        launch_vec = (pick_any && disp_ready) ? pick_grant : '0;
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        rsv_entry #(
            .DATA_W  (DATA_W),
            .TAG_W   (TAG_W),
            .ENT_TAG (TAG_W'(g + 1))
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_vec[g]),
            .ld_op     (rsv_pkg::rsv_op_e'(iss_op)),
            .ld_vj     (iss_vj),
            .ld_qj     (iss_qj),
            .ld_vk     (iss_vk),
            .ld_qk     (iss_qk),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .launch    (launch_vec[g]),
            .busy      (busy_vec[g]),
            .ready     (ready_vec[g]),
            .op        (op_arr[g]),
            .vj        (vj_arr[g]),
            .vk        (vk_arr[g])
        );
    end

    // Steer the offered slot's contents onto the dispatch port.
    always_comb begin
        disp_valid = pick_any;
        disp_tag   = pick_any ? (TAG_W'(pick_idx) + TAG_W'(1)) : '0;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (pick_grant[i]) begin
                disp_op = OP_W'(op_arr[i]);
                disp_a  = vj_arr[i];
                disp_b  = vk_arr[i];
            end
        end
    end

    AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_vec & busy_vec) == '0);  // R3

    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch_vec));  // R7

    AST_LAUNCH_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_vec & ~ready_vec) == '0);  // R4

    AST_LOAD_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_vec & $past(alloc_grant)) != '0);  // R2

endmodule

// File: tb/rsv_pool_test.sv
`timescale 1ns/1ps
module rsv_pool_test;

    localparam int N  = 3;
    localparam int DW = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = '0;
    logic [DW-1:0] iss_vj = '0;
    logic [TW-1:0] iss_qj = '0;
    logic [DW-1:0] iss_vk = '0;
    logic [TW-1:0] iss_qk = '0;
    logic          iss_full;
    logic [TW-1:0] iss_tag;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [DW-1:0] bus_value = '0;
    logic          disp_ready = 1'b0;
    logic          disp_valid;
    logic [TW-1:0] disp_tag;
    logic [1:0]    disp_op;
    logic [DW-1:0] disp_a;
    logic [DW-1:0] disp_b;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference slot model
    bit            m_busy [N];
    bit            m_fly  [N];
    logic [1:0]    m_op   [N];
    logic [DW-1:0] m_vj   [N];
    logic [DW-1:0] m_vk   [N];
    logic [TW-1:0] m_qj   [N];
    logic [TW-1:0] m_qk   [N];

    always #4 clk = ~clk;  // 125 MHz

    rsv_pool #(.NUM_ENT(N), .DATA_W(DW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_full(iss_full), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b)
    );

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !m_fly[i] && m_qj[i] == 0 && m_qk[i] == 0) return i;
        return -1;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all ports against the model (state-only outputs).
    task automatic compare_all();
        int f = lowest_free();
        int r = lowest_ready();
        chk("R3 full", 64'(iss_full), 64'(f < 0));
        chk("R2 iss_tag", 64'(iss_tag), (f < 0) ? 64'd0 : 64'(f + 1));
        chk("R7 disp_valid", 64'(disp_valid), 64'(r >= 0));
        if (r >= 0) begin
            chk("R7 disp_tag", 64'(disp_tag), 64'(r + 1));
            chk("R10 disp_op", 64'(disp_op), 64'(m_op[r]));
            chk("R5 disp_a", 64'(disp_a), 64'(m_vj[r]));
            chk("R5 disp_b", 64'(disp_b), 64'(m_vk[r]));
        end
    endtask

    // Advance the model by one clock edge using the current inputs.
    task automatic model_edge();
        int  f = lowest_free();
        int  r = lowest_ready();
        bit  live = bus_valid && bus_tag != 0;
        for (int i = 0; i < N; i++) begin
            if (iss_valid && f == i) begin
                m_busy[i] = 1; m_fly[i] = 0; m_op[i] = iss_op;
                if (live && iss_qj == bus_tag) begin m_vj[i] = bus_value; m_qj[i] = 0; end
                else begin m_vj[i] = iss_vj; m_qj[i] = iss_qj; end
                if (live && iss_qk == bus_tag) begin m_vk[i] = bus_value; m_qk[i] = 0; end
                else begin m_vk[i] = iss_vk; m_qk[i] = iss_qk; end
            end else if (m_busy[i]) begin
                if (live && bus_tag == TW'(i + 1)) begin
                    m_busy[i] = 0; m_fly[i] = 0;
                end else begin
                    if (r == i && disp_ready) m_fly[i] = 1;
                    if (live && m_qj[i] != 0 && m_qj[i] == bus_tag) begin m_vj[i] = bus_value; m_qj[i] = 0; end
                    if (live && m_qk[i] != 0 && m_qk[i] == bus_tag) begin m_vk[i] = bus_value; m_qk[i] = 0; end
                end
            end
        end
    endtask

    // One cycle: drive at negedge, compare, take the edge, end at negedge.
    task automatic step(bit iv, logic [1:0] op, logic [DW-1:0] vj, logic [TW-1:0] qj,
                        logic [DW-1:0] vk, logic [TW-1:0] qk,
                        bit bv, logic [TW-1:0] bt, logic [DW-1:0] bval, bit dr);
        iss_valid = iv; iss_op = op; iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
        bus_valid = bv; bus_tag = bt; bus_value = bval; disp_ready = dr;
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_fly[i] = 0; m_op[i] = 0;
            m_vj[i] = 0; m_vk[i] = 0; m_qj[i] = 0; m_qk[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 full", 64'(iss_full), 0);
        chk("R1 disp_valid", 64'(disp_valid), 0);
        chk("R1 iss_tag", 64'(iss_tag), 1);

        // Fill: slot1 waits on tag3, slot2 ready, slot3 waits on tag1
        step(1, 2'd0, 32'd10, 4'd0, 32'd0, 4'd3, 0, 0, 0, 0);
        step(1, 2'd1, 32'd20, 4'd0, 32'd4, 4'd0, 0, 0, 0, 0);
        step(1, 2'd2, 32'd0, 4'd1, 32'd6, 4'd0, 0, 0, 0, 0);
        chk("R3 full after three", 64'(iss_full), 1);
        chk("R4 pending slot skipped", 64'(disp_tag), 2);
        chk("R10 sub opcode", 64'(disp_op), 1);

        // R3: issue while full is dropped
        step(1, 2'd3, 32'hDEAD, 4'd0, 32'hBEEF, 4'd0, 0, 0, 0, 0);
        chk("R3 still offers slot2", 64'(disp_tag), 2);

        // R7/R8: launch slot2, then it is not offered again
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 no reoffer", 64'(disp_valid), 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 still busy", 64'(iss_full), 1);

        // R9: own tag frees slot2
        step(0, 0, 0, 0, 0, 0, 1, 4'd2, 32'd16, 0);
        chk("R9 freed", 64'(iss_full), 0);
        chk("R9 tag reused", 64'(iss_tag), 2);

        // R11: inert broadcasts
        step(0, 0, 0, 0, 0, 0, 1, 4'd0, 32'd99, 0);
        step(0, 0, 0, 0, 0, 0, 0, 4'd3, 32'd55, 0);
        chk("R11 no capture", 64'(disp_valid), 0);

        // R6: issue into slot2 waiting on tag3 while tag3 broadcasts
        step(1, 2'd3, 32'd0, 4'd3, 32'd8, 4'd0, 1, 4'd3, 32'd77, 0);
        chk("R5 slot1 captured", 64'(disp_tag), 1);
        chk("R5 slot1 operand", 64'(disp_b), 77);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R6 same-cycle capture", 64'(disp_a), 77);
        chk("R7 next lowest", 64'(disp_tag), 2);
        chk("R10 div opcode", 64'(disp_op), 3);

        // Drain everything
        step(0, 0, 0, 0, 0, 0, 1, 4'd1, 32'd1, 1);
        step(0, 0, 0, 0, 0, 0, 1, 4'd2, 32'd2, 0);
        step(0, 0, 0, 0, 0, 0, 1, 4'd3, 32'd3, 0);
        chk("R9 all free", 64'(iss_tag), 1);

        // Constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            bit            iv = ($urandom % 3) != 0;
            logic [TW-1:0] qj = ($urandom % 2) ? TW'($urandom % (N + 1)) : '0;
            logic [TW-1:0] qk = ($urandom % 2) ? TW'($urandom % (N + 1)) : '0;
            bit            bv = ($urandom % 2) != 0;
            logic [TW-1:0] bt = TW'($urandom % (N + 2));
            step(iv, 2'($urandom), $urandom, qj, $urandom, qk,
                 bv, bt, $urandom, ($urandom % 3) != 0);
        end
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule